// File: doc/BRIEF.md
# Channel Protection Status Register Unit

This block keeps the protection status of one load channel. Nine fault inputs arrive from the sensing and protection logic, possibly asynchronous to the register clock. Each input is passed through a two-stage synchronizer and then latched into a sticky condition bit. A latched bit is released only when both of these are true: its fault input is inactive, and a protection-clear strobe has been seen. An over-temperature condition also drives a channel-off output, which holds the channel disabled until that bit is released.

Condition bits feed a transition stage. Two programmable masks choose, for each bit, whether a rising edge, a falling edge or both set the matching event bit. Event bits accumulate until the event register is read, and the read clears them. An enable mask selects which event bits are ORed into a single summary output, which feeds the next level of status reporting.

Software reaches five registers through a simple address/strobe port. Each register is 9 bits wide, and reads return it zero-extended to 16 bits.

Top module: `chan_prot_status`

## Requirements
- R1: Fault input bit k maps to condition bit k: 0 over-temperature, 1 over-voltage, 2 over-current, 3 over-power, 4 reverse input, 5 sync timeout, 6 sine-current limit, 7 fan failure, 8 remote inhibit. A condition bit reads 1 while its fault is latched.
- R2: A fault input held high sets its condition bit within 3 clock edges (two synchronizer stages plus the latch). The bit stays set while the input stays high.
- R3: Once the fault input is inactive, a latched bit stays set until a clear strobe arrives. The bit then reads 0 one cycle after the strobe.
- R4: A clear strobe that arrives while a fault is still active leaves the bit set and arms it. An armed bit clears by itself within 3 edges after its input deasserts.
- R5: The channel-off output equals 1 whenever condition bit 0 (over-temperature) is latched, and 0 otherwise.
- R6: A rising condition edge sets event bit k only if PTR bit k is 1. A falling condition edge sets event bit k only if NTR bit k is 1.
- R7: A read of the event register returns its value and clears it. An edge that sets an event bit in the same cycle as that read survives the clear, and the next read returns it.
- R8: The summary output is the OR over all bits of (event AND enable).
- R9: After reset, PTR reads 0x01FF, and NTR, enable, event and condition read 0. The channel-off output is 0.
- R10: The register map is: address 0 condition (read only), 1 PTR, 2 NTR, 3 event (read clears), 4 enable. Addresses 5 to 7 read 0. Writes to addresses 0 and 3 have no effect. Bits 15:9 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_in | input | 9 | Raw fault conditions, asynchronous |
| prot_clr | input | 1 | One-cycle protection-clear strobe |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe (clears the event register at address 3) |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| chan_off | output | 1 | Forces the channel off during over-temperature |
| summary | output | 1 | OR of the enabled event bits |

## Verification
Faults are driven in several sequences, and each one isolates a single release path:
- A fault pulse followed later by a clear checks that the bit stays sticky until cleared.
- A clear sent during an active fault, followed by deassertion, checks the armed self-release.
- A fault dropped with no clear afterwards checks that the bit does not release on its own.

The transition masks are set to rise-only, fall-only and both. Each setting leaves a different event pattern for the same fault pulse. A read timed to land on the edge where an event is captured shows whether the clear or the new event wins. Enable masks that match the pending event bits, and masks that do not, tell the summary's AND stage apart from its OR stage.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int NF = 9;
  localparam int DW = 16;
  localparam int AW = 3;

  localparam logic [AW-1:0] ADR_COND = 3'd0;
  localparam logic [AW-1:0] ADR_PTR  = 3'd1;
  localparam logic [AW-1:0] ADR_NTR  = 3'd2;
  localparam logic [AW-1:0] ADR_EVT  = 3'd3;
  localparam logic [AW-1:0] ADR_ENA  = 3'd4;

  localparam int BIT_OVERTEMP = 0;

  // Event bits hit by this cycle's condition edges after filtering
  function automatic logic [NF-1:0] edge_hits(
    input logic [NF-1:0] cur, input logic [NF-1:0] prev,
    input logic [NF-1:0] rise_msk, input logic [NF-1:0] fall_msk);
    return (cur & ~prev & rise_msk) | (~cur & prev & fall_msk);
  endfunction

  // Sticky bits released this cycle
  function automatic logic [NF-1:0] release_bits(
    input logic [NF-1:0] cond, input logic [NF-1:0] live,
    input logic clr, input logic [NF-1:0] armed);
    return cond & ~live & ({NF{clr}} | armed);
  endfunction
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/cps_latch.sv
module cps_latch
  import cps_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] live,
  input  logic          clr,
  output logic [NF-1:0] cond,
  output logic [NF-1:0] armed
);
  logic [NF-1:0] rel;
  logic [NF-1:0] cond_n;
  logic [NF-1:0] armed_n;

  always_comb begin
    rel     = release_bits(cond, live, clr, armed);
    cond_n  = live | (cond & ~rel);
    armed_n = (armed | ({NF{clr}} & live)) & cond_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond  <= '0;
      armed <= '0;
    end else begin
      cond  <= cond_n;
      armed <= armed_n;
    end
  end

  // R2: a live fault is latched on the next edge
  a_r2_fault_latches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cond & $past(live)) == $past(live)));

  // R3: a bit only drops after a clear strobe or while armed
  a_r3_release_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cond) & ~cond) != '0) |-> ($past(clr) || ($past(armed) != '0)));

  // R4: no bit is released while its fault was live
  a_r4_no_release_live: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cond) & ~cond & $past(live)) == '0));
endmodule

// File: rtl/cps_event.sv
module cps_event
  import cps_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] cond,
  input  logic [NF-1:0] ptr,
  input  logic [NF-1:0] ntr,
  input  logic          rd_clr,
  output logic [NF-1:0] evt,
  output logic [NF-1:0] hit
);
  logic [NF-1:0] prev_q;

  assign hit = edge_hits(cond, prev_q, ptr, ntr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt    <= '0;
    end else begin
      prev_q <= cond;
      evt    <= (rd_clr ? '0 : evt) | hit;
    end
  end

  // R6: new event bits only come from filtered edges
  a_r6_only_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt & ~$past(evt) & ~$past(hit)) == '0));

  // R7: a read leaves exactly the edges captured in that cycle
  a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (evt == $past(hit)));
endmodule

// File: rtl/chan_prot_status.sv
module chan_prot_status
  import cps_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] fault_in,
  input  logic          prot_clr,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_rd,
  output logic [DW-1:0] reg_rdata,
  output logic          chan_off,
  output logic          summary
);
  localparam logic [NF-1:0] PTR_RST = {NF{1'b1}};

  logic [NF-1:0] live;
  logic [NF-1:0] cond;
  logic [NF-1:0] armed;
  logic [NF-1:0] evt;
  logic [NF-1:0] hit;
  logic [NF-1:0] ptr_q, ntr_q, ena_q;
  logic [NF-1:0] rd_mux;
  logic          evt_rd;
  logic          unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DW-1:NF];
  assign evt_rd = reg_rd && (reg_addr == ADR_EVT);

  cps_sync #(.W(NF)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(fault_in), .sync_out(live));

  cps_latch latch_i (
    .clk(clk), .rst_n(rst_n), .live(live), .clr(prot_clr),
    .cond(cond), .armed(armed));

  cps_event event_i (
    .clk(clk), .rst_n(rst_n), .cond(cond), .ptr(ptr_q), .ntr(ntr_q),
    .rd_clr(evt_rd), .evt(evt), .hit(hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= PTR_RST;
      ntr_q <= '0;
      ena_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADR_PTR: ptr_q <= reg_wdata[NF-1:0];
        ADR_NTR: ntr_q <= reg_wdata[NF-1:0];
        ADR_ENA: ena_q <= reg_wdata[NF-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      ADR_COND: rd_mux = cond;
      ADR_PTR:  rd_mux = ptr_q;
      ADR_NTR:  rd_mux = ntr_q;
      ADR_EVT:  rd_mux = evt;
      ADR_ENA:  rd_mux = ena_q;
      default:  rd_mux = '0;
    endcase
  end

  assign reg_rdata = {{(DW-NF){1'b0}}, rd_mux};
  assign chan_off  = cond[BIT_OVERTEMP];
  assign summary   = |(evt & ena_q);

  // R5: a live over-temperature fault forces the channel off next cycle
  a_r5_overtemp_off: assert property (@(posedge clk) disable iff (!rst_n)
    live[BIT_OVERTEMP] |=> chan_off);

  // R8: with nothing enabled the summary stays low
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> !summary);
endmodule

// File: tb/chan_prot_status_tb_top.sv
module chan_prot_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  fault_in = '0;
  logic        prot_clr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic        chan_off;
  logic        summary;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chan_prot_status dut_i (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .prot_clr(prot_clr),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .chan_off(chan_off),
    .summary(summary));

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  // peek without clearing anything
  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b0;
    #0.5;
    d = reg_rdata;
  endtask

  // strobed read, clears the event register at address 3
  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #0.5;
    d = reg_rdata;
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    prot_clr = 1'b1;
    tick();
    prot_clr = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(3'd0, v); check("R9 cond", v, 16'h0000);
    peek(3'd1, v); check("R9 ptr", v, 16'h01FF);
    peek(3'd2, v); check("R9 ntr", v, 16'h0000);
    peek(3'd3, v); check("R9 evt", v, 16'h0000);
    peek(3'd4, v); check("R9 ena", v, 16'h0000);
    check("R9 chan_off", {15'd0, chan_off}, 16'd0);
  endtask

  task automatic t_map();
    logic [15:0] v;
    wr(3'd0, 16'hFFFF); peek(3'd0, v); check("R10 cond write ignored", v, 16'h0000);
    wr(3'd3, 16'hFFFF); peek(3'd3, v); check("R10 evt write ignored", v, 16'h0000);
    wr(3'd4, 16'hFFFF); peek(3'd4, v); check("R10 ena zero-extended", v, 16'h01FF);
    wr(3'd2, 16'h00A5); peek(3'd2, v); check("R10 ntr", v, 16'h00A5);
    peek(3'd5, v); check("R10 unmapped", v, 16'h0000);
    wr(3'd4, 16'h0000); wr(3'd2, 16'h0000);
  endtask

  task automatic t_bitmap();
    logic [15:0] v;
    for (int k = 0; k < 9; k++) begin
      fault_in = 9'(1 << k);
      tick(4);
      peek(3'd0, v); check($sformatf("R1 bit %0d", k), v, 16'(1 << k));
      check("R5 chan_off", {15'd0, chan_off}, (k == 0) ? 16'd1 : 16'd0);
      fault_in = '0;
      tick(3);
      pulse_clr();
    end
    peek(3'd0, v); check("R3 all released", v, 16'h0000);
    rd(3'd3, v); check("R6 ptr-only events", v, 16'h01FF);
  endtask

  task automatic t_sticky();
    logic [15:0] v;
    fault_in = 9'h004;
    tick(2);
    peek(3'd0, v); check("R2 not yet latched", v, 16'h0000);
    tick();
    peek(3'd0, v); check("R2 latched at 3rd edge", v, 16'h0004);
    tick(10);
    peek(3'd0, v); check("R2 held while live", v, 16'h0004);
    fault_in = '0;
    tick(8);
    peek(3'd0, v); check("R3 sticky without clear", v, 16'h0004);
    pulse_clr();
    peek(3'd0, v); check("R3 clear releases", v, 16'h0000);
  endtask

  task automatic t_armed();
    logic [15:0] v;
    fault_in = 9'h001;
    tick(4);
    pulse_clr();
    tick();
    peek(3'd0, v); check("R4 clear while live keeps bit", v, 16'h0001);
    check("R5 still off", {15'd0, chan_off}, 16'd1);
    fault_in = '0;
    tick(3);
    peek(3'd0, v); check("R4 armed self-release", v, 16'h0000);
    check("R5 back on", {15'd0, chan_off}, 16'd0);
  endtask

  task automatic t_filters();
    logic [15:0] v;
    rd(3'd3, v);
    wr(3'd1, 16'h0000); wr(3'd2, 16'h0008);
    fault_in = 9'h008; tick(5);
    peek(3'd3, v); check("R6 rise filtered out", v, 16'h0000);
    fault_in = '0; tick(3); pulse_clr(); tick(2);
    rd(3'd3, v); check("R6 fall captured", v, 16'h0008);
    wr(3'd1, 16'h0010); wr(3'd2, 16'h0010);
    fault_in = 9'h010; tick(5);
    rd(3'd3, v); check("R6 both: rise", v, 16'h0010);
    fault_in = '0; tick(3); pulse_clr(); tick(2);
    rd(3'd3, v); check("R6 both: fall", v, 16'h0010);
    wr(3'd1, 16'h01FF); wr(3'd2, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    fault_in = 9'h020; tick(5);
    fault_in = 9'h022;
    tick(3);
    // the event for bit 1 is captured at the next edge, during this read
    rd(3'd3, v); check("R7 read returns old", v, 16'h0020);
    peek(3'd3, v); check("R7 new event survives", v, 16'h0002);
    rd(3'd3, v); rd(3'd3, v); check("R7 cleared", v, 16'h0000);
    fault_in = '0; tick(3); pulse_clr(); tick(2);
  endtask

  task automatic t_summary();
    logic [15:0] v;
    rd(3'd3, v);
    wr(3'd4, 16'h0080);
    fault_in = 9'h040; tick(5); fault_in = '0;
    check("R8 not enabled", {15'd0, summary}, 16'd0);
    fault_in = 9'h080; tick(5);
    check("R8 enabled event", {15'd0, summary}, 16'd1);
    rd(3'd3, v);
    check("R8 drops after read", {15'd0, summary}, 16'd0);
    fault_in = '0; tick(3); pulse_clr();
    wr(3'd4, 16'h0000);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_map();
    t_bitmap();
    t_sticky();
    t_armed();
    t_filters();
    t_collide();
    t_summary();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule